// File: doc/BRIEF.md
# Private Peripheral Window Decoder

This block sits behind the bus port of a private 4 KB peripheral window that up to four processor cores share. It receives the 12-bit offset of each access inside the window, together with the number of the core making the request. It then steers the access to one of three places. The first is a small snoop-control register set, which the block holds itself. The second is the register bank of one core's interrupt interface. The third is one of eight per-core timer or watchdog instances. Each of the last two targets is reachable in two ways: through an alias page that always means "the requester's own bank", or through an indexed page range that picks the core from the address.

The interrupt-interface banks and the timers sit outside this block. The decoder hands them a select, a core number or instance index, and a short register offset. It multiplexes their read data back to the requester. It also turns the event line of each timer instance into a one-cycle private interrupt request. That request is aimed at the core that owns the instance, using interrupt number 29 for the timer and 30 for the watchdog. Accesses to offsets that are not defined raise an error flag for the same cycle.

Top module: `ppr_decoder`

## Requirements
- R1: Offset 0x000 is a control register. A write there stores `req_wdata[0]`, and the stored bit appears on `scu_en` one cycle later. A read returns that bit in bit 0 and zeros in every other bit. After reset the bit is 0.
- R2: Reads from 0x004 return 0x000000F3. Reads from 0x008 and from 0x00C return 0. A write to 0x00C is accepted without error and changes nothing.
- R3: Every other offset below 0x100 raises `rsp_err` and reads as 0. This includes writes to the read-only offsets 0x004 and 0x008.
- R4: Offsets 0x100–0x1FF assert `gic_sel`, with `gic_cpu` equal to `req_cpu` and `gic_off` equal to offset bits 7:0. A read returns `gic_rdata`.
- R5: Offsets 0x200–0x5FF assert `gic_sel`, with `gic_cpu` equal to (offset−0x200)>>8 and `gic_off` equal to offset bits 7:0.
- R6: Offsets 0x600–0x6FF assert `tmr_sel`, with `tmr_idx` equal to `req_cpu`×2 plus offset bit 5 and `tmr_off` equal to offset bits 3:0. A read returns `tmr_rdata`.
- R7: Offsets 0x700–0xAFF assert `tmr_sel`, with `tmr_idx` equal to ((offset−0x700)>>8)×2 plus offset bit 5.
- R8: Offsets 0xB00–0xFFF raise `rsp_err`, select nothing, read as 0, and a write there changes nothing.
- R9: When `tmr_evt[i]` rises (low on the previous clock edge, high on this one), `ppi_set[i]` is high for exactly the next cycle. Bit i requests interrupt 29+(i&1) on core i>>1. A level that stays high gives no further pulses.
- R10: `gic_sel`, `tmr_sel` and `rsp_err` are all low while `req_valid` is low, and at most one of them is high at any time.
- R11: Reset is asynchronous and active-low. Its release takes effect on the third rising clock edge after `rst_n` rises. Writes and timer edges sampled on the first two edges after release are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Offset within the 4 KB window |
| req_wdata | input | DATA_W | Write data |
| req_cpu | input | CPU_W | Number of the requesting core |
| rsp_rdata | output | DATA_W | Read data (0 on writes and when idle) |
| rsp_err | output | 1 | Access to an undefined offset |
| gic_sel | output | 1 | Interrupt-interface bank selected |
| gic_cpu | output | CPU_W | Core whose interface bank is addressed |
| gic_off | output | 8 | Register offset inside that bank |
| gic_rdata | input | DATA_W | Read data from the interface bank |
| tmr_sel | output | 1 | Timer instance selected |
| tmr_idx | output | CPU_W+1 | Timer instance index |
| tmr_off | output | 4 | Register offset inside the instance |
| tmr_rdata | input | DATA_W | Read data from the timer instance |
| tgt_write | output | 1 | Write strobe forwarded to the targets |
| tgt_wdata | output | DATA_W | Write data forwarded to the targets |
| scu_en | output | 1 | Stored control bit |
| tmr_evt | input | 2*NCPU | Event level of each timer instance |
| ppi_set | output | 2*NCPU | One-cycle private interrupt request per instance |

## Verification
Some rules are checked by the assertions on every cycle:
- the select lines are mutually exclusive and quiet when no access is present;
- an alias page follows the requester's core number;
- pages above the timer range always raise the error flag;
- the configuration read returns its constant;
- the control bit tracks writes and holds otherwise;
- interrupt pulses come only from fresh rising edges and never last two cycles.

The full address map, by contrast, can only be shown by the bench scenarios. That covers the core number for each indexed page, the timer-versus-watchdog choice taken from bit 5, and which control-range offsets are legal for reads and which for writes. The same holds for the two dropped edges after reset release and for read data passing through from the outside targets.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

  typedef enum logic [2:0] {
    RG_CTRL      = 3'd0,
    RG_GIC_ALIAS = 3'd1,
    RG_GIC_IDX   = 3'd2,
    RG_TMR_ALIAS = 3'd3,
    RG_TMR_IDX   = 3'd4,
    RG_BAD       = 3'd5
  } ppr_region_e;

  localparam int unsigned OFF_W      = 12;
  localparam int unsigned PAGE_W     = 4;
  localparam int unsigned SUB_W      = 8;
  localparam int unsigned TREG_W     = 4;
  localparam int unsigned TSEL_BIT   = 5;

  // Pages (256-byte units) fixed by the window layout
  localparam int unsigned PG_CTRL      = 0;
  localparam int unsigned PG_GIC_ALIAS = 1;
  localparam int unsigned PG_GIC_IDX   = 2;

  // Control-range register offsets
  localparam logic [SUB_W-1:0] SUB_CTRL = 8'h00;
  localparam logic [SUB_W-1:0] SUB_CFG  = 8'h04;
  localparam logic [SUB_W-1:0] SUB_STAT = 8'h08;
  localparam logic [SUB_W-1:0] SUB_INV  = 8'h0C;
  localparam logic [7:0]       CFG_WORD = 8'hF3;

endpackage

// File: rtl/ppr_region_dec.sv
module ppr_region_dec
  import ppr_pkg::*;
#(
  parameter int unsigned NCPU  = 4,
  parameter int unsigned CPU_W = 2
) (
  input  logic [PAGE_W-1:0] page,
  input  logic              tsel,
  input  logic [CPU_W-1:0]  req_cpu,
  output ppr_region_e       region,
  output logic [CPU_W-1:0]  bank_cpu,
  output logic [CPU_W:0]    tmr_inst
);

  localparam int unsigned PX_W = PAGE_W + 1;
  localparam logic [PX_W-1:0] PX_CTRL      = PX_W'(PG_CTRL);
  localparam logic [PX_W-1:0] PX_GIC_ALIAS = PX_W'(PG_GIC_ALIAS);
  localparam logic [PX_W-1:0] PX_GIC_IDX   = PX_W'(PG_GIC_IDX);
  localparam logic [PX_W-1:0] PX_GIC_END   = PX_W'(PG_GIC_IDX + NCPU);
  localparam logic [PX_W-1:0] PX_TMR_ALIAS = PX_GIC_END;
  localparam logic [PX_W-1:0] PX_TMR_IDX   = PX_W'(PG_GIC_IDX + NCPU + 1);
  localparam logic [PX_W-1:0] PX_TMR_END   = PX_W'(PG_GIC_IDX + 2 * NCPU + 1);

  logic [PX_W-1:0] page_x;

  always_comb begin
    page_x   = {1'b0, page};
    region   = RG_BAD;
    bank_cpu = req_cpu;
    if (page_x == PX_CTRL) begin
      region = RG_CTRL;
    end else if (page_x == PX_GIC_ALIAS) begin
      region = RG_GIC_ALIAS;
    end else if (page_x < PX_GIC_END) begin
      region   = RG_GIC_IDX;
      bank_cpu = CPU_W'(page_x - PX_GIC_IDX);
    end else if (page_x == PX_TMR_ALIAS) begin
      region = RG_TMR_ALIAS;
    end else if (page_x < PX_TMR_END) begin
      region   = RG_TMR_IDX;
      bank_cpu = CPU_W'(page_x - PX_TMR_IDX);
    end
    tmr_inst = {bank_cpu, tsel};
  end

endmodule

// File: rtl/ppr_ctrl_regs.sv
module ppr_ctrl_regs
  import ppr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              wr,
  input  logic [SUB_W-1:0]  sub,
  input  logic              wbit,
  output logic [DATA_W-1:0] rdata,
  output logic              bad,
  output logic              en
);

  logic en_q, en_d, en_we;
  logic bad_raw;

  always_comb begin
    en_d    = en_q;
    en_we   = 1'b0;
    bad_raw = 1'b0;
    rdata   = '0;
    case (sub)
      SUB_CTRL: begin
        rdata = DATA_W'(en_q);
        if (hit && wr) begin
          en_we = 1'b1;
          en_d  = wbit;
        end
      end
      SUB_CFG:  begin
        rdata   = DATA_W'(CFG_WORD);
        bad_raw = wr;
      end
      SUB_STAT: bad_raw = wr;
      SUB_INV:  bad_raw = 1'b0;
      default:  bad_raw = 1'b1;
    endcase
    bad = hit & bad_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  assign en = en_q;

endmodule

// File: rtl/ppr_tick_route.sv
module ppr_tick_route #(
  parameter int unsigned NTMR = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTMR-1:0] evt,
  output logic [NTMR-1:0] ppi_set
);

  // Bit i targets core i/2, interrupt number 29 + (i % 2)
  for (genvar i = 0; i < NTMR; i++) begin : g_inst
    logic prev_q, set_q;
    logic set_d;

    always_comb begin
      set_d = evt[i] & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        set_q  <= 1'b0;
      end else begin
        prev_q <= evt[i];
        set_q  <= set_d;
      end
    end

    assign ppi_set[i] = set_q;
  end

endmodule

// File: rtl/ppr_decoder.sv
module ppr_decoder
  import ppr_pkg::*;
#(
  parameter  int unsigned NCPU   = 4,
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned CPU_W  = $clog2(NCPU),
  localparam int unsigned NTMR   = 2 * NCPU
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CPU_W-1:0]  req_cpu,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              gic_sel,
  output logic [CPU_W-1:0]  gic_cpu,
  output logic [SUB_W-1:0]  gic_off,
  input  logic [DATA_W-1:0] gic_rdata,
  output logic              tmr_sel,
  output logic [CPU_W:0]    tmr_idx,
  output logic [TREG_W-1:0] tmr_off,
  input  logic [DATA_W-1:0] tmr_rdata,
  output logic              tgt_write,
  output logic [DATA_W-1:0] tgt_wdata,
  output logic              scu_en,
  input  logic [NTMR-1:0]   tmr_evt,
  output logic [NTMR-1:0]   ppi_set
);

  // Reset: asynchronous assertion, two-flop synchronous release
  logic rst_s1_q, rst_s2_q, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign rst_int_n = rst_s2_q;

  ppr_region_e       region;
  logic [CPU_W-1:0]  bank_cpu;
  logic [CPU_W:0]    tmr_inst;
  logic              ctrl_hit, ctrl_bad;
  logic [DATA_W-1:0] ctrl_rdata;
  logic [DATA_W-1:0] rd_mux;
  logic              err_raw, gic_hit, tmr_hit;

  ppr_region_dec #(
    .NCPU  (NCPU),
    .CPU_W (CPU_W)
  ) u_dec (
    .page     (req_addr[OFF_W-1:SUB_W]),
    .tsel     (req_addr[TSEL_BIT]),
    .req_cpu  (req_cpu),
    .region   (region),
    .bank_cpu (bank_cpu),
    .tmr_inst (tmr_inst)
  );

  assign ctrl_hit = req_valid && (region == RG_CTRL);

  ppr_ctrl_regs #(
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk   (clk),
    .rst_n (rst_int_n),
    .hit   (ctrl_hit),
    .wr    (req_write),
    .sub   (req_addr[SUB_W-1:0]),
    .wbit  (req_wdata[0]),
    .rdata (ctrl_rdata),
    .bad   (ctrl_bad),
    .en    (scu_en)
  );

  ppr_tick_route #(
    .NTMR (NTMR)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .evt     (tmr_evt),
    .ppi_set (ppi_set)
  );

  always_comb begin
    gic_hit = 1'b0;
    tmr_hit = 1'b0;
    err_raw = 1'b0;
    rd_mux  = '0;
    case (region)
      RG_CTRL: begin
        rd_mux  = ctrl_rdata;
        err_raw = ctrl_bad;
      end
      RG_GIC_ALIAS, RG_GIC_IDX: begin
        gic_hit = 1'b1;
        rd_mux  = gic_rdata;
      end
      RG_TMR_ALIAS, RG_TMR_IDX: begin
        tmr_hit = 1'b1;
        rd_mux  = tmr_rdata;
      end
      default: err_raw = 1'b1;
    endcase
  end

  assign gic_sel   = req_valid & gic_hit;
  assign tmr_sel   = req_valid & tmr_hit;
  assign rsp_err   = req_valid & err_raw;
  assign rsp_rdata = (req_valid && !req_write && !err_raw) ? rd_mux : '0;
  assign gic_cpu   = bank_cpu;
  assign gic_off   = req_addr[SUB_W-1:0];
  assign tmr_idx   = tmr_inst;
  assign tmr_off   = req_addr[TREG_W-1:0];
  assign tgt_write = req_write;
  assign tgt_wdata = req_wdata;

endmodule

// File: rtl/ppr_decoder_chk.sv
module ppr_decoder_chk #(
  parameter int unsigned NCPU   = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CPU_W  = 2,
  parameter int unsigned NTMR   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [11:0]       req_addr,
  input logic              wbit,
  input logic [CPU_W-1:0]  req_cpu,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              gic_sel,
  input logic [CPU_W-1:0]  gic_cpu,
  input logic              tmr_sel,
  input logic [CPU_W:0]    tmr_idx,
  input logic              scu_en,
  input logic [NTMR-1:0]   tmr_evt,
  input logic [NTMR-1:0]   ppi_set
);

  localparam logic [3:0] PG_TALIAS = 4'(2 + NCPU);
  localparam logic [4:0] PG_TOP    = 5'(3 + 2 * NCPU);

  // Edges seen since rst_n rose, saturating
  logic [2:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_q <= 3'd0;
    else if (since_q != 3'd7) since_q <= since_q + 3'd1;
  end

  logic live_regs, live_edge, ctl_wr;
  assign live_regs = (since_q >= 3'd2);
  assign live_edge = (since_q >= 3'd4);
  assign ctl_wr    = req_valid && req_write && (req_addr == 12'h000);

  assert_excl_targets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gic_sel, tmr_sel, rsp_err}));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(gic_sel || tmr_sel || rsp_err));

  assert_gic_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[11:8] == 4'h1) |-> (gic_sel && gic_cpu == req_cpu));

  assert_tmr_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[11:8] == PG_TALIAS) |-> (tmr_sel && tmr_idx == {req_cpu, req_addr[5]}));

  assert_high_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && {1'b0, req_addr[11:8]} >= PG_TOP) |-> (rsp_err && rsp_rdata == '0 && !gic_sel && !tmr_sel));

  assert_cfg_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 12'h004) |-> (rsp_rdata == DATA_W'(8'hF3) && !rsp_err));

  assert_ctl_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (live_regs && ctl_wr) |=> (scu_en == $past(wbit)));

  assert_ctl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (live_regs && !ctl_wr) |=> $stable(scu_en));

  assert_ppi_fresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ppi_set & ~$past(tmr_evt)) == '0);

  assert_ppi_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ppi_set & $past(ppi_set)) == '0);

  assert_ppi_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    live_edge |-> (ppi_set == ($past(tmr_evt) & ~$past(tmr_evt, 2))));

endmodule

bind ppr_decoder ppr_decoder_chk #(
  .NCPU   (NCPU),
  .DATA_W (DATA_W),
  .CPU_W  (CPU_W),
  .NTMR   (NTMR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .wbit      (req_wdata[0]),
  .req_cpu   (req_cpu),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .gic_sel   (gic_sel),
  .gic_cpu   (gic_cpu),
  .tmr_sel   (tmr_sel),
  .tmr_idx   (tmr_idx),
  .scu_en    (scu_en),
  .tmr_evt   (tmr_evt),
  .ppi_set   (ppi_set)
);

// File: tb/ppr_decoder_tb_top.sv
module ppr_decoder_tb_top;

  localparam int NCPU = 4;
  localparam int DW   = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_cpu = '0;
  logic [DW-1:0] rsp_rdata, gic_rdata = '0, tmr_rdata = '0, tgt_wdata;
  logic          rsp_err, gic_sel, tmr_sel, tgt_write, scu_en;
  logic [1:0]    gic_cpu;
  logic [7:0]    gic_off;
  logic [2:0]    tmr_idx;
  logic [3:0]    tmr_off;
  logic [7:0]    tmr_evt = '0, ppi_set;

  always #5 clk = ~clk;

  ppr_decoder #(.NCPU(NCPU), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .gic_sel(gic_sel),
    .gic_cpu(gic_cpu), .gic_off(gic_off), .gic_rdata(gic_rdata),
    .tmr_sel(tmr_sel), .tmr_idx(tmr_idx), .tmr_off(tmr_off),
    .tmr_rdata(tmr_rdata), .tgt_write(tgt_write), .tgt_wdata(tgt_wdata),
    .scu_en(scu_en), .tmr_evt(tmr_evt), .ppi_set(ppi_set)
  );

  int n_cmp = 0, n_bad = 0, n_step = 0, m_edges = 0;
  bit done = 1'b0;
  bit m_scu = 1'b0;
  bit [7:0] m_prev = '0, m_ppi = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int off);
    if (off == 0) return "R1 ctrl";
    if (off == 4 || off == 8 || off == 12) return "R2 fixed";
    if (off < 'h100) return "R3 ctrl-illegal";
    if (off < 'h200) return "R4 gic-alias";
    if (off < 'h600) return "R5 gic-indexed";
    if (off < 'h700) return "R6 timer-alias";
    if (off < 'hB00) return "R7 timer-indexed";
    return "R8 high-illegal";
  endfunction

  task automatic compare_now();
    int off, cpu_g, cpu_t;
    bit eg, et, ee, legal;
    logic [31:0] er;
    string tg;
    off = int'(req_addr);
    tg  = req_valid ? tag_of(off) : "R10 idle";
    eg  = req_valid && off >= 'h100 && off < 'h600;
    et  = req_valid && off >= 'h600 && off < 'hB00;
    legal = (off == 0) || (off == 'hC) || (!req_write && (off == 4 || off == 8));
    ee  = req_valid && (off >= 'hB00 || (off < 'h100 && !legal));
    cpu_g = (off < 'h200) ? int'(req_cpu) : (off - 'h200) / 256;
    cpu_t = (off < 'h700) ? int'(req_cpu) : (off - 'h700) / 256;
    er = '0;
    if (req_valid && !req_write) begin
      if (off == 0) er = {31'd0, m_scu};
      else if (off == 4) er = 32'h0000_00F3;
      else if (eg) er = gic_rdata;
      else if (et) er = tmr_rdata;
    end
    chk({tg, " sel/err"}, {29'd0, gic_sel, tmr_sel, rsp_err}, {29'd0, eg, et, ee});
    chk({tg, " rdata"}, rsp_rdata, er);
    if (eg) begin
      chk({tg, " gic_cpu"}, 32'(gic_cpu), 32'(cpu_g));
      chk({tg, " gic_off"}, 32'(gic_off), 32'(off % 256));
    end
    if (et) begin
      chk({tg, " tmr_idx"}, 32'(tmr_idx), 32'(cpu_t * 2 + (off / 32) % 2));
      chk({tg, " tmr_off"}, 32'(tmr_off), 32'(off % 16));
    end
    if (eg || et) begin
      chk({tg, " fwd write"}, 32'(tgt_write), 32'(req_write));
      chk({tg, " fwd wdata"}, tgt_wdata, req_wdata);
    end
    chk("R1 scu_en", 32'(scu_en), 32'(m_scu));
    chk("R9 ppi_set", 32'(ppi_set), 32'(m_ppi));
  endtask

  task automatic step(bit v, bit w, int a, logic [31:0] d, int c, logic [7:0] e);
    req_valid = v; req_write = w; req_addr = 12'(a);
    req_wdata = d; req_cpu = 2'(c); tmr_evt = e;
    gic_rdata = 32'hA500_0000 ^ 32'(n_step * 7);
    tmr_rdata = 32'h5A00_0000 + 32'(n_step * 3);
    n_step++;
    #4;
    compare_now();
    @(posedge clk);
    if (m_edges >= 2) begin
      if (v && w && a == 0) m_scu = d[0];
      m_ppi  = e & ~m_prev;
      m_prev = e;
    end
    m_edges++;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    #4;
    chk("R11 reset scu_en", 32'(scu_en), 0);
    chk("R11 reset ppi_set", 32'(ppi_set), 0);
    chk("R11 reset err", 32'(rsp_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_edges = 0;
    // R11: writes and edges on the first two edges after release are dropped
    step(1, 1, 'h000, 32'h1, 0, 8'h01);
    step(1, 1, 'h000, 32'h1, 0, 8'h01);
    step(0, 0, 'h000, 0, 0, 8'h01);
    step(1, 0, 'h000, 0, 0, 8'h00);
    // R1 control register
    step(1, 1, 'h000, 32'hFFFF_FFFF, 1, 0);
    step(1, 0, 'h000, 0, 2, 0);
    step(1, 1, 'h000, 32'hFFFF_FFFE, 3, 0);
    step(1, 0, 'h000, 0, 0, 0);
    step(1, 1, 'h000, 32'h1, 0, 0);
    // R2 fixed reads, invalidate write no effect
    step(1, 1, 'h00C, 32'h0, 0, 0);
    step(1, 0, 'h00C, 0, 0, 0);
    step(1, 0, 'h004, 0, 1, 0);
    step(1, 0, 'h008, 0, 2, 0);
    step(1, 0, 'h000, 0, 0, 0);
    // R3 illegal control offsets
    step(1, 1, 'h004, 32'h0, 0, 0);
    step(1, 1, 'h008, 32'h0, 0, 0);
    step(1, 0, 'h001, 0, 0, 0);
    step(1, 0, 'h010, 0, 0, 0);
    step(1, 1, 'h0FC, 32'h0, 0, 0);
    step(1, 0, 'h000, 0, 0, 0);
    // R4 / R5 interface banks
    for (int c = 0; c < 4; c++) step(1, 0, 'h100 + c * 'h14, 0, c, 0);
    for (int c = 0; c < 4; c++) step(1, c % 2, 'h200 + c * 'h100 + 'hF8, 32'h1234_0000 + c, 3 - c, 0);
    // R6 / R7 timers and watchdogs
    for (int c = 0; c < 4; c++) step(1, 0, 'h600 + c * 'h10, 0, c, 0);
    for (int c = 0; c < 4; c++) step(1, 0, 'h700 + c * 'h100 + 'h24, 0, 3 - c, 0);
    step(1, 1, 'hAFF, 32'hDEAD_0000, 0, 0);
    // R8 high offsets; write must not disturb state
    step(1, 1, 'hB00, 32'h0, 0, 0);
    step(1, 0, 'hFFF, 0, 2, 0);
    step(1, 0, 'h000, 0, 0, 0);
    // R10 idle with garbage address
    step(0, 1, 'hB40, 32'h0, 1, 0);
    step(0, 0, 'h004, 0, 1, 0);
    step(0, 1, 'h000, 32'h0, 1, 0);
    step(1, 0, 'h000, 0, 0, 0);
    // Sweep over the window
    for (int p = 0; p < 4096; p += 'h34)
      step(1, (p / 4) % 2 == 1, p, 32'(p * 5 + 1), (p / 64) % 4, 0);
    // R9 interrupt pulses
    step(0, 0, 0, 0, 0, 8'h01);
    step(0, 0, 0, 0, 0, 8'h01);
    step(0, 0, 0, 0, 0, 8'h03);
    step(0, 0, 0, 0, 0, 8'h00);
    step(0, 0, 0, 0, 0, 8'hFF);
    step(0, 0, 0, 0, 0, 8'hFF);
    step(0, 0, 0, 0, 0, 8'hAA);
    step(0, 0, 0, 0, 0, 8'h55);
    step(0, 0, 0, 0, 0, 8'hAA);
    step(1, 0, 'h600, 0, 1, 8'h80);
    step(0, 0, 0, 0, 0, 8'h00);
    step(0, 0, 0, 0, 0, 8'h00);
    // R11 asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    chk("R11 async clear scu_en", 32'(scu_en), 0);
    m_scu = 1'b0; m_prev = '0; m_ppi = '0;
    @(negedge clk);
    rst_n = 1'b1;
    m_edges = 0;
    step(1, 1, 'h000, 32'h1, 0, 8'h04);
    step(1, 1, 'h000, 32'h1, 0, 8'h04);
    step(1, 0, 'h000, 0, 0, 8'h04);
    step(0, 0, 0, 0, 0, 8'h00);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule